// File: doc/BRIEF.md
# Range-Aware Triangular Averaging Filter

This block smooths a stream of signed angular-rate samples with a triangular (Bartlett) weighting window. The window is built from two cascaded moving sums of equal length N = 2^M. The result therefore spans 2N-1 samples, and its weights rise linearly from 1 to N and fall back to 1. The weighted sum is scaled back to sample units by an arithmetic right shift of 2M bits, so the block needs no divider.

A 16-bit configuration word sets the behaviour. It holds a 4-bit window exponent, a stored-only bandwidth flag and a 3-bit one-hot range field. A byte-wide register port writes and reads the word as two bytes. The narrower measurement ranges need a minimum amount of averaging. The block enforces that minimum by raising a too-small exponent to the floor of the active range. Whenever the effective exponent changes, the filter history is discarded and the output stays silent until the window has filled again.

Top module: `rate_bartlett_filter`

## Requirements
- R1: After reset, the low configuration byte (address 0x38) reads 0x02 and the high byte (address 0x39) reads 0x04. This is full-scale range with M = 2.
- R2: Low-byte bit 7 is a bandwidth flag that is stored and read back and has no effect on filtering. Low-byte bits [6:4] and high-byte bits [7:3] always read 0.
- R3: A written exponent above 7 (low-byte bits [3:0]) is stored and used as 7.
- R4: With range code 010 (high-byte bits [2:0]) the exponent is raised to at least 2. With code 001 it is raised to at least 4. The raised value is what reads back.
- R5: Writing a new range code re-applies the floor to the exponent already stored.
- R6: Any range code other than 001 or 010 gives no floor. The code reads back as written.
- R7: Each valid output equals floor(sum over the last 2N-1 accepted samples of w_j·x_(n-j) / 2^(2M)), where w_j = min(j+1, 2N-1-j) and N = 2^M.
- R8: After reset or after any change of the effective exponent, no output is valid until 2N-1 samples have been accepted. After that, each accepted sample yields exactly one output.
- R9: A sample accepted on clock edge k appears with out_valid high after edge k+2.
- R10: Writes to addresses other than 0x38 and 0x39 change nothing. Reads of such addresses return 0. Read data is registered and valid one cycle after the address is presented.
- R11: Full-scale inputs at M = 7 produce exact results without overflow. For example, a constant -32768 yields -32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | DATA_W | Signed input rate sample |
| reg_wr_en | input | 1 | Register byte write strobe |
| reg_addr | input | ADDR_W | Register byte address for write and read |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Registered read byte for reg_addr |
| out_valid | output | 1 | Filtered sample qualifier |
| out_sample | output | DATA_W | Signed filtered sample |

## Verification
The bench builds the block with its default parameters: 16-bit samples, a maximum exponent of 7 and the register bytes at 0x38/0x39. This makes the full 128-deep history and the exponent cap reachable, as well as the exact -2^29 boundary of the second accumulator under sustained full-scale negative input. Runs at M = 0, 2, 4, 5 and 7 cover the degenerate pass-through window, the range floors, a re-clamp triggered by a range write and the longest refill of 255 samples. A reference model computes the triangular sum directly from the sample history.

// File: rtl/bw_pkg.sv
package bw_pkg;

  // One-hot range codes held in the high configuration byte
  localparam logic [2:0] RNG_FULL    = 3'b100;
  localparam logic [2:0] RNG_HALF    = 3'b010;
  localparam logic [2:0] RNG_QUARTER = 3'b001;

  // Smallest window exponent allowed per range; illegal codes act as full scale
  function automatic logic [3:0] min_exp_for(input logic [2:0] rng);
    case (rng)
      RNG_HALF:    return 4'd2;
      RNG_QUARTER: return 4'd4;
      default:     return 4'd0;
    endcase
  endfunction

  // Cap at the implemented maximum first, then raise to the range floor
  function automatic logic [3:0] clamp_exp(input logic [3:0] req,
                                           input logic [2:0] rng,
                                           input logic [3:0] cap);
    logic [3:0] v;
    v = (req > cap) ? cap : req;
    if (v < min_exp_for(rng)) v = min_exp_for(rng);
    return v;
  endfunction

endpackage

// File: rtl/bw_cfg_regs.sv
module bw_cfg_regs
  import bw_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter int                MAX_M   = 7,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h38,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h39
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [3:0]        exp_m
);

  localparam logic [3:0] EXP_CAP = 4'(MAX_M);
  localparam logic [3:0] EXP_RST = (MAX_M < 2) ? 4'(MAX_M) : 4'd2;

  logic       bw_flag;
  logic [2:0] rng;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_m   <= EXP_RST;
      bw_flag <= 1'b0;
      rng     <= RNG_FULL;
      rdata   <= 8'h00;
    end else begin
      if (wr_en && addr == LO_ADDR) begin
        exp_m   <= clamp_exp(wdata[3:0], rng, EXP_CAP);
        bw_flag <= wdata[7];
      end else if (wr_en && addr == HI_ADDR) begin
        rng   <= wdata[2:0];
        exp_m <= clamp_exp(exp_m, wdata[2:0], EXP_CAP);
      end
      case (addr)
        LO_ADDR: rdata <= {bw_flag, 3'b000, exp_m};
        HI_ADDR: rdata <= {5'b00000, rng};
        default: rdata <= 8'h00;
      endcase
    end
  end

  AST_EXP_CAP: assert property (@(posedge clk) disable iff (rst)
    exp_m <= EXP_CAP);                                               // R3
  AST_HALF_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (rng == RNG_HALF) |-> (exp_m >= 4'd2 || EXP_CAP < 4'd2));        // R4
  AST_QUARTER_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (rng == RNG_QUARTER) |-> (exp_m >= 4'd4 || EXP_CAP < 4'd4));     // R4
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != LO_ADDR && addr != HI_ADDR)
      |=> ($stable(exp_m) && $stable(rng) && $stable(bw_flag)));     // R10

endmodule

// File: rtl/bw_boxcar.sv
module bw_boxcar #(
  parameter int IN_W  = 16,
  parameter int MAX_M = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic [3:0]                    exp_m,
  input  logic                          in_valid,
  input  logic signed [IN_W-1:0]        in_data,
  output logic                          out_valid,
  output logic                          out_full,
  output logic signed [IN_W+MAX_M-1:0]  out_sum
);

  localparam int DEPTH = 1 << MAX_M;
  localparam int PTR_W = MAX_M;
  localparam int CNT_W = MAX_M + 1;
  localparam int SUM_W = IN_W + MAX_M;

  logic signed [IN_W-1:0]  hist [DEPTH];
  logic [PTR_W-1:0]        wptr;
  logic [PTR_W-1:0]        rptr;
  logic [CNT_W-1:0]        fill;
  logic [CNT_W-1:0]        span;
  logic signed [IN_W-1:0]  leaving;
  logic signed [SUM_W-1:0] acc;

  // Window length and the slot holding the sample that drops out
  always_comb begin
    span    = CNT_W'(1) << exp_m;
    rptr    = wptr - span[PTR_W-1:0];
    leaving = (fill >= span) ? hist[rptr] : '0;
  end

  // History storage: plain write port, no reset
  always_ff @(posedge clk) begin
    if (in_valid) hist[wptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr      <= '0;
      fill      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_full  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wptr     <= wptr + 1'b1;
        if (fill < span) fill <= fill + 1'b1;
        acc      <= acc + SUM_W'(in_data) - SUM_W'(leaving);
        out_full <= (fill + 1'b1 >= span);
      end
    end
  end

  assign out_sum = acc;

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (rst || clr)
    fill <= span);                                                   // R8
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));                                  // R9

endmodule

// File: rtl/rate_bartlett_filter.sv
module rate_bartlett_filter #(
  parameter int                DATA_W  = 16,
  parameter int                MAX_M   = 7,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h38,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h39
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic                     reg_wr_en,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);

  localparam int SUM1_W = DATA_W + MAX_M;
  localparam int SUM2_W = SUM1_W + MAX_M;

  logic [3:0]               exp_m;
  logic [3:0]               exp_seen;
  logic                     clr;
  logic                     s1_valid, s1_full;
  logic signed [SUM1_W-1:0] s1_sum;
  logic                     s2_in_valid;
  logic                     s2_valid, s2_full;
  logic signed [SUM2_W-1:0] s2_sum;
  logic signed [SUM2_W-1:0] scaled;

  bw_cfg_regs #(
    .ADDR_W (ADDR_W),
    .MAX_M  (MAX_M),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
  ) u_cfg (
    .clk  (clk),
    .rst  (rst),
    .wr_en(reg_wr_en),
    .addr (reg_addr),
    .wdata(reg_wdata),
    .rdata(reg_rdata),
    .exp_m(exp_m)
  );

  // A change of window exponent flushes both stages
  always_ff @(posedge clk) begin
    if (rst) exp_seen <= '0;
    else     exp_seen <= exp_m;
  end
  assign clr = (exp_m != exp_seen);

  bw_boxcar #(.IN_W(DATA_W), .MAX_M(MAX_M)) u_stage1 (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .exp_m    (exp_m),
    .in_valid (in_valid),
    .in_data  (in_sample),
    .out_valid(s1_valid),
    .out_full (s1_full),
    .out_sum  (s1_sum)
  );

  // Second stage only sees sums taken over a complete first window
  assign s2_in_valid = s1_valid && s1_full;

  bw_boxcar #(.IN_W(SUM1_W), .MAX_M(MAX_M)) u_stage2 (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .exp_m    (exp_m),
    .in_valid (s2_in_valid),
    .in_data  (s1_sum),
    .out_valid(s2_valid),
    .out_full (s2_full),
    .out_sum  (s2_sum)
  );

  assign scaled = s2_sum >>> {exp_m, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= s2_valid && s2_full && !clr;
      if (s2_valid) out_sample <= scaled[DATA_W-1:0];
    end
  end

  AST_CLR_SILENCES: assert property (@(posedge clk) disable iff (rst)
    clr |=> !out_valid);                                             // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_full) |->
      ((scaled[SUM2_W-1:DATA_W-1] == '0) ||
       (scaled[SUM2_W-1:DATA_W-1] == '1)));                          // R11

endmodule

// File: tb/rate_bartlett_filter_bench.sv
module rate_bartlett_filter_bench;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     in_valid = 1'b0;
  logic signed [DATA_W-1:0] in_sample = '0;
  logic                     reg_wr_en = 1'b0;
  logic [ADDR_W-1:0]        reg_addr = '0;
  logic [7:0]               reg_wdata = '0;
  logic [7:0]               reg_rdata;
  logic                     out_valid;
  logic signed [DATA_W-1:0] out_sample;

  rate_bartlett_filter u_rate_bartlett_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .out_valid(out_valid), .out_sample(out_sample)
  );

  always #4 clk = ~clk;   // 125 MHz

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard: expected value and expected cycle
  int     q_val[$];
  longint q_cyc[$];

  // Reference configuration model
  int     m_ref = 2;
  int     rng_ref = 4;
  int     hist[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic int clamp_ref(input int req, input int rng);
    int v;
    v = (req > 7) ? 7 : req;
    if (rng == 2 && v < 2) v = 2;   // range 010
    if (rng == 1 && v < 4) v = 4;   // range 001
    return v;
  endfunction

  // Monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_val.size() == 0) begin
        chk(1'b0, "R8 unexpected output", out_sample, 0);
      end else begin
        int     ev;
        longint ec;
        ev = q_val.pop_front();
        ec = q_cyc.pop_front();
        chk(int'(out_sample) == ev, "R7 R11 output value", out_sample, ev);
        chk(cyc == ec, "R9 output cycle", cyc, ec);
      end
    end
  end

  task automatic send(input int x);
    int     w;
    longint acc;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 16'(x);
    hist.push_back(x);
    if (hist.size() > 300) void'(hist.pop_front());
    w = 2 * (1 << m_ref) - 1;
    if (hist.size() >= w) begin
      acc = 0;
      for (int j = 0; j < w; j++) begin
        int wt;
        wt = (j + 1 < w - j) ? j + 1 : w - j;
        acc += longint'(wt) * longint'(hist[hist.size() - 1 - j]);
      end
      q_val.push_back(int'(acc >>> (2 * m_ref)));
      q_cyc.push_back(cyc + 3);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    idle(6);
    chk(q_val.size() == 0, tag, q_val.size(), 0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    int nm;
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    nm = m_ref;
    if (a == 8'h38) nm = clamp_ref(int'(d[3:0]), rng_ref);
    else if (a == 8'h39) begin
      rng_ref = int'(d[2:0]);
      nm = clamp_ref(m_ref, rng_ref);
    end
    if (nm != m_ref) hist.delete();
    m_ref = nm;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    rd(8'h38, 8'h02, "R1 reset low byte");
    rd(8'h39, 8'h04, "R1 reset high byte");

    // M=2: ramp, back-to-back then with gaps
    for (int i = 0; i < 12; i++) send(i * 1000 - 5000);
    for (int i = 0; i < 6; i++) begin send(3000 - i * 777); idle(2); end
    drain("R8 all M=2 outputs produced");

    // Unused bits dropped, bandwidth flag kept, M=5
    wr(8'h38, 8'hF5);
    rd(8'h38, 8'h85, "R2 low byte readback");
    for (int i = 0; i < 80; i++) send(int'($urandom_range(0, 65535)) - 32768);
    drain("R8 M=5 refill and outputs");

    // Exponent above cap
    wr(8'h38, 8'h0F);
    rd(8'h38, 8'h07, "R3 exponent capped at 7");
    for (int i = 0; i < 300; i++) send(-32768);
    for (int i = 0; i < 20; i++) send(32767);
    drain("R11 M=7 full-scale run complete");

    // Half range: upper bits dropped, floor 2
    wr(8'h39, 8'hFA);
    rd(8'h39, 8'h02, "R2 high byte unused bits zero");
    rd(8'h38, 8'h07, "R4 M kept when above floor");
    wr(8'h38, 8'h01);
    rd(8'h38, 8'h02, "R4 half-range floor");
    for (int i = 0; i < 20; i++) send(int'($urandom_range(0, 20000)) - 10000);
    drain("R4 M=2 after floor");

    // Quarter range re-clamps stored exponent
    wr(8'h39, 8'h01);
    rd(8'h38, 8'h04, "R5 range write re-clamps");
    for (int i = 0; i < 40; i++) send(int'($urandom_range(0, 65535)) - 32768);
    drain("R5 M=4 outputs");
    wr(8'h38, 8'h00);
    rd(8'h38, 8'h04, "R4 quarter-range floor");

    // Illegal code: no floor
    wr(8'h39, 8'h07);
    rd(8'h39, 8'h07, "R6 illegal code reads back");
    wr(8'h38, 8'h00);
    rd(8'h38, 8'h00, "R6 no floor for illegal code");
    for (int i = 0; i < 10; i++) send(i * 4321 - 20000);
    drain("R7 M=0 pass-through");

    // Foreign address
    wr(8'h37, 8'hFF);
    wr(8'h3A, 8'hFF);
    rd(8'h38, 8'h00, "R10 low byte unchanged");
    rd(8'h39, 8'h07, "R10 high byte unchanged");
    rd(8'h37, 8'h00, "R10 foreign read zero");
    for (int i = 0; i < 5; i++) send(-i * 999);
    drain("R10 filtering undisturbed");

    // Bandwidth flag has no effect on the output
    wr(8'h38, 8'h82);
    rd(8'h38, 8'h82, "R2 bandwidth flag stored");
    for (int i = 0; i < 15; i++) send(i * 2000 - 14000);
    drain("R2 bandwidth flag no effect");

    finish_run();
  end

endmodule